// File: doc/BRIEF.md
# Adaptive Window Word Reducer

This block narrows a 31-bit signed accumulator sample to the 14-bit signed word that a DAC takes. Keeping only the top bits wipes out quiet signals: anything below the 17 discarded low bits comes out as zero. In its adaptive mode the block instead finds, for each sample, how many copies of the sign bit sit directly below the top bit. It then moves the 14-bit window down by that many places, up to the bottom of the word, so the output keeps the sign and the leading bit that carries magnitude.

The number of places moved is sent out with every sample. An external variable-gain stage can use it to restore the original scale. A fixed mode that always takes the top 14 bits is kept for comparison. The mode is chosen per sample. Results appear a fixed two clock edges after the input is taken, with a valid flag beside them.

Top module: `sliding_trunc`

## Requirements
- R1: While rst_ni is low and after its release until the first output, valid_o, sample_o and shift_o are all zero.
- R2: A sample taken with valid_i high at clock edge k appears on the outputs, with valid_o high, after edge k+2. valid_o is low after any edge k+2 whose edge k had valid_i low.
- R3: With mode_i = 0 (fixed), sample_o equals sample_i[30:17] and shift_o is 0.
- R4: With mode_i = 1 (adaptive), the shift s is the number of consecutive bits from bit 29 downward that equal bit 30, capped at 17, and sample_o equals bits [30:17] of sample_i shifted left by s.
- R5: In adaptive mode the sign bit of sample_o (bit 13) equals bit 30 of the input, so negative inputs are handled like positive ones.
- R6: In adaptive mode any non-zero input gives a non-zero sample_o.
- R7: shift_o never exceeds 17. An input of 0 gives shift 17 with output 0, and an input of -1 gives shift 17 with output -1.
- R8: When no valid sample reaches the output stage, sample_o and shift_o keep their previous values.
- R9: Samples may arrive on back-to-back cycles with the mode changing between them, and each one is reduced in its own mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Input sample is present |
| mode_i | input | 1 | 0 selects the fixed top-bit slice, 1 selects the adaptive window |
| sample_i | input | 31 | Signed wide input sample |
| valid_o | output | 1 | Output sample is present |
| sample_o | output | 14 | Signed reduced sample |
| shift_o | output | 5 | Places the window was moved down, 0 to 17 |

## Verification
A wrong count of sign bits shows up two edges later in two places: shift_o is off by the error, and sample_o is scaled by a power of two or loses its sign. Sign-bit inputs exercise both polarities, magnitudes sit on every side of the cap at 17, and the exact shift value is checked on each output. A stuck or skipped pipeline register shows up as valid_o one cycle early or late. It also shows up as a back-to-back sample picking up its neighbour's mode or data, which the streaming test with alternating modes exposes on the very next output.

// File: rtl/sliding_trunc_pkg.sv
package sliding_trunc_pkg;
  typedef enum logic {
    TRUNC_FIXED = 1'b0,
    TRUNC_SLIDE = 1'b1
  } trunc_mode_e;
endpackage

// File: rtl/lead_sign_count.sv
// Counts sign copies directly under the top bit, capped at MAX_CNT.
module lead_sign_count #(
  parameter int MAX_CNT = 17,
  parameter int CNT_W   = $clog2(MAX_CNT + 1)
) (
  input  logic [MAX_CNT:0]   top_i,
  output logic [CNT_W-1:0]   cnt_o
);
  logic [MAX_CNT-1:0] run;

  for (genvar j = 0; j < MAX_CNT; j++) begin : g_run
    logic eq;
    assign eq = (top_i[MAX_CNT-1-j] == top_i[MAX_CNT]);
    if (j == 0) begin : g_first
      assign run[j] = eq;
    end else begin : g_next
      assign run[j] = run[j-1] & eq;
    end
  end

  // run is a prefix mask, so its popcount is the run length
  always_comb begin
    cnt_o = '0;
    for (int j = 0; j < MAX_CNT; j++) cnt_o = cnt_o + CNT_W'(run[j]);
  end
endmodule

// File: rtl/window_select.sv
module window_select #(
  parameter int IN_W  = 31,
  parameter int OUT_W = 14,
  parameter int SH_W  = 5
) (
  input  logic [IN_W-1:0]  data_i,
  input  logic [SH_W-1:0]  shift_i,
  output logic [OUT_W-1:0] data_o
);
  int base;
  always_comb begin
    base   = IN_W - 1 - int'(shift_i);
    data_o = data_i[base -: OUT_W];
  end
endmodule

// File: rtl/sliding_trunc.sv
module sliding_trunc
  import sliding_trunc_pkg::*;
#(
  parameter int IN_W      = 31,
  parameter int OUT_W     = 14,
  localparam int SHIFT_MAX = IN_W - OUT_W,
  localparam int SH_W      = $clog2(SHIFT_MAX + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             valid_i,
  input  logic             mode_i,
  input  logic [IN_W-1:0]  sample_i,
  output logic             valid_o,
  output logic [OUT_W-1:0] sample_o,
  output logic [SH_W-1:0]  shift_o
);
  trunc_mode_e     mode;
  logic [SH_W-1:0] lead_cnt;
  logic [SH_W-1:0] s0_shift;

  logic            s1_valid;
  logic [IN_W-1:0] s1_data;
  logic [SH_W-1:0] s1_shift;
  logic [OUT_W-1:0] s1_win;

  assign mode = trunc_mode_e'(mode_i);

  lead_sign_count #(
    .MAX_CNT(SHIFT_MAX),
    .CNT_W  (SH_W)
  ) u_lead (
    .top_i(sample_i[IN_W-1 -: SHIFT_MAX+1]),
    .cnt_o(lead_cnt)
  );

  assign s0_shift = (mode == TRUNC_SLIDE) ? lead_cnt : '0;

  // stage 1: capture sample and window position
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_valid <= 1'b0;
      s1_data  <= '0;
      s1_shift <= '0;
    end else begin
      s1_valid <= valid_i;
      if (valid_i) begin
        s1_data  <= sample_i;
        s1_shift <= s0_shift;
      end
    end
  end

  window_select #(
    .IN_W (IN_W),
    .OUT_W(OUT_W),
    .SH_W (SH_W)
  ) u_win (
    .data_i (s1_data),
    .shift_i(s1_shift),
    .data_o (s1_win)
  );

  // stage 2: output register
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o  <= 1'b0;
      sample_o <= '0;
      shift_o  <= '0;
    end else begin
      valid_o <= s1_valid;
      if (s1_valid) begin
        sample_o <= s1_win;
        shift_o  <= s1_shift;
      end
    end
  end
endmodule

// File: rtl/sliding_trunc_chk.sv
module sliding_trunc_chk #(
  parameter int IN_W  = 31,
  parameter int OUT_W = 14,
  parameter int SH_W  = 5
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             valid_i,
  input logic             mode_i,
  input logic [IN_W-1:0]  sample_i,
  input logic             valid_o,
  input logic [OUT_W-1:0] sample_o,
  input logic [SH_W-1:0]  shift_o
);
  localparam int SHIFT_MAX = IN_W - OUT_W;

  logic [1:0] seen;
  logic       warm;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) seen <= '0;
    else if (seen != 2'd2) seen <= seen + 2'd1;
  end
  assign warm = (seen == 2'd2);

  p_reset_quiet_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !warm |-> !valid_o);

  p_latency_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    warm |-> (valid_o == $past(valid_i, 2)));

  p_fixed_shift_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (warm && valid_o && !$past(mode_i, 2)) |-> (shift_o == '0));

  p_sign_kept_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (warm && valid_o && $past(mode_i, 2))
      |-> (sample_o[OUT_W-1] == $past(sample_i[IN_W-1], 2)));

  p_nonzero_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (warm && valid_o && $past(mode_i, 2) && ($past(sample_i, 2) != '0))
      |-> (sample_o != '0));

  p_shift_range_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    shift_o <= SH_W'(SHIFT_MAX));

  p_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (warm && !valid_o) |-> ($stable(sample_o) && $stable(shift_o)));
endmodule

bind sliding_trunc sliding_trunc_chk #(
  .IN_W (IN_W),
  .OUT_W(OUT_W),
  .SH_W (SH_W)
) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .valid_i (valid_i),
  .mode_i  (mode_i),
  .sample_i(sample_i),
  .valid_o (valid_o),
  .sample_o(sample_o),
  .shift_o (shift_o)
);

// File: tb/sliding_trunc_test.sv
`timescale 1ns/1ps
module sliding_trunc_test;
  localparam int IN_W = 31;
  localparam int OUT_W = 14;
  localparam int SH_W = 5;

  logic             clk_i = 1'b0;
  logic             rst_ni = 1'b0;
  logic             valid_i = 1'b0;
  logic             mode_i = 1'b0;
  logic [IN_W-1:0]  sample_i = '0;
  logic             valid_o;
  logic [OUT_W-1:0] sample_o;
  logic [SH_W-1:0]  shift_o;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #10 clk_i = ~clk_i;

  sliding_trunc uut (
    .clk_i(clk_i), .rst_ni(rst_ni), .valid_i(valid_i), .mode_i(mode_i),
    .sample_i(sample_i), .valid_o(valid_o), .sample_o(sample_o), .shift_o(shift_o)
  );

  task automatic chk(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic void model(input logic [IN_W-1:0] x, input bit slide,
                                output logic [OUT_W-1:0] o, output logic [SH_W-1:0] s);
    int r = 0;
    logic [IN_W-1:0] t;
    if (slide) begin
      for (int j = IN_W-2; j >= 0; j--) begin
        if (x[j] == x[IN_W-1]) r++;
        else break;
      end
      if (r > IN_W-OUT_W) r = IN_W-OUT_W;
    end
    t = x << r;
    o = t[IN_W-1 -: OUT_W];
    s = SH_W'(r);
  endfunction

  // send one sample, check latency and result
  task automatic one(input string req, input logic [IN_W-1:0] x, input bit slide);
    logic [OUT_W-1:0] eo;
    logic [SH_W-1:0] es;
    model(x, slide, eo, es);
    @(negedge clk_i);
    valid_i = 1'b1; mode_i = slide; sample_i = x;
    @(negedge clk_i);
    valid_i = 1'b0; sample_i = ~x;
    chk({req, " R2 early"}, valid_o, 0);
    @(negedge clk_i);
    chk({req, " R2 valid"}, valid_o, 1);
    chk({req, " data"}, sample_o, eo);
    chk({req, " shift"}, shift_o, es);
  endtask

  task automatic t_reset;
    chk("R1 valid", valid_o, 0);
    chk("R1 data", sample_o, 0);
    chk("R1 shift", shift_o, 0);
    @(negedge clk_i); rst_ni = 1'b1;
    @(negedge clk_i);
    chk("R1 after release", valid_o, 0);
  endtask

  task automatic t_fixed;
    one("R3 big", 31'h3A5C_1234, 1'b0);
    one("R3 small gives zero", 31'h0000_0123, 1'b0);
    one("R3 negative", 31'h7FF0_0000, 1'b0);
  endtask

  task automatic t_slide;
    one("R4 top", 31'h2000_0001, 1'b1);
    one("R4 mid", 31'h0001_2345, 1'b1);
    one("R4 cap edge", 31'h0000_2000, 1'b1);
    one("R4 below cap", 31'h0000_1FFF, 1'b1);
    one("R5 negative", 31'h7FFF_8ABC, 1'b1);
    one("R5 negative large", 31'h4000_0000, 1'b1);
    one("R6 one", 31'h0000_0001, 1'b1);
    one("R6 small neg", 31'h7FFF_FFFE, 1'b1);
  endtask

  task automatic t_extremes;
    one("R7 zero", 31'h0, 1'b1);
    chk("R7 zero shift", shift_o, 17);
    one("R7 minus one", 31'h7FFF_FFFF, 1'b1);
    chk("R7 minus one data", sample_o, 14'h3FFF);
  endtask

  task automatic t_hold;
    logic [OUT_W-1:0] d;
    logic [SH_W-1:0] s;
    one("R8 prime", 31'h0000_4321, 1'b1);
    d = sample_o; s = shift_o;
    @(negedge clk_i); mode_i = 1'b0; sample_i = 31'h5555_5555;
    repeat (3) @(negedge clk_i);
    chk("R8 valid low", valid_o, 0);
    chk("R8 data held", sample_o, d);
    chk("R8 shift held", shift_o, s);
  endtask

  task automatic t_stream;
    logic [IN_W-1:0] xs [8];
    logic [OUT_W-1:0] eo;
    logic [SH_W-1:0] es;
    xs = '{31'h0000_0F00, 31'h0000_0F00, 31'h7FFF_F0F0, 31'h1234_5678,
           31'h0000_0003, 31'h7ABC_DEF0, 31'h0040_0000, 31'h7FFF_FFC1};
    @(negedge clk_i);
    for (int i = 0; i < 10; i++) begin
      if (i >= 2) begin
        model(xs[i-2], (i % 2) == 0, eo, es);
        chk("R9 valid", valid_o, 1);
        chk("R9 data", sample_o, eo);
        chk("R9 shift", shift_o, es);
      end
      if (i < 8) begin
        valid_i = 1'b1; mode_i = (i % 2) == 0; sample_i = xs[i];
      end else valid_i = 1'b0;
      @(negedge clk_i);
    end
  endtask

  initial begin
    t_reset;
    t_fixed;
    t_slide;
    t_extremes;
    t_hold;
    t_stream;
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule